// File: doc/BRIEF.md
# Data-Memory Return Stack Controller

This block keeps subroutine and interrupt return state in a stack carved out of a 4-bit-wide data RAM. A call pushes the 12-bit return address. An accepted interrupt pushes that address and the 4-bit processor flags. A plain return pops the address. An interrupt return pops both the address and the flags. Each stack location is a four-nibble frame. Location n starts at RAM address 0x40 + 4n, and locations run from 0 to 14.

The stack pointer is a software-visible nibble that holds the number of the next free location. It has no hardware reset, so software must load it before the first call; 12 is the usual value. The core decodes the pointer's RAM address and drives the block's pointer write port. The pointer never holds 15.

A save writes the frame at the current pointer and then moves the pointer down. A restore moves the pointer up first and then reads the frame. The core hands over one operation at a time through a valid/ready handshake. The block moves one nibble per cycle on the RAM port, which has a one-cycle read latency. It raises a one-cycle done pulse when the operation is complete. It does not check for overflow or underflow, so a runaway stack silently overwrites whatever occupies the frames it reaches.

Top module: `nibstack_ctrl`

## Requirements
- R1: A pointer write with a value from 0 to 14 sets the stack pointer, and `sp_rd` shows the new value on the next cycle.
- R2: A pointer write with the value 15 is ignored, and the stack pointer never reads as 15.
- R3: Location n occupies RAM addresses 0x40+4n to 0x43+4n. Offsets 0, 1 and 2 hold PC bits [3:0], [7:4] and [11:8]. Offset 3 holds the flags. Every RAM write falls in the range 0x40 to 0x7B.
- R4: Operation code 0 (call) writes three PC nibbles at the current location, leaves offset 3 unwritten, and then decrements the pointer.
- R5: Operation code 1 (interrupt) writes three PC nibbles and the flags at the current location, and then decrements the pointer.
- R6: Operation code 2 (return) first increments the pointer, then reads three nibbles from the new location into `ret_pc`. `ret_flags` is left unchanged.
- R7: Operation code 3 (interrupt return) first increments the pointer, then reads the new location into `ret_pc` and `ret_flags`.
- R8: The pointer counts modulo 15. Decrementing 0 gives 14, and incrementing 14 gives 0. There is no overflow guard, so a push overwrites whatever the frame held before.
- R9: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle at the end of each operation, and the results and pointer are final in that cycle.
- R10: The block issues at most one RAM access per cycle and never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer (the pointer itself is not reset) |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 0 call, 1 interrupt, 2 return, 3 interrupt return |
| req_pc | input | 12 | Return address to save |
| req_flags | input | 4 | Flags to save on interrupt |
| req_ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| ret_pc | output | 12 | Restored return address |
| ret_flags | output | 4 | Restored flags |
| sp_wr_en | input | 1 | Software write to the stack pointer |
| sp_wr_data | input | 4 | Value written to the stack pointer |
| sp_rd | output | 4 | Current stack pointer |
| mem_addr | output | 7 | RAM nibble address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 4 | RAM write data |
| mem_re | output | 1 | RAM read strobe (data returned next cycle) |
| mem_rdata | input | 4 | RAM read data |

## Verification
The bench pushes a call frame over a pre-filled flag slot and checks that the slot is still intact afterwards. A design that wrote four nibbles on every save would corrupt that slot. It nests an interrupt inside a call and unwinds both frames, so any swap of post-decrement and pre-increment ordering shows up as a read from the wrong location. It drives the pointer across the 0/14 boundary in both directions and checks that the user nibble at 0x40 is overwritten. Wrapping to 15, or refusing the push, would both show up there. It also writes 15 to the pointer, checks that the plain return leaves the restored flags alone, and watches the RAM port for writes outside the stack region and for reads and writes in the same cycle.

// File: rtl/nibstack_ctrl.sv
module nibstack_ctrl #(
  parameter logic [6:0] BASE_ADDR = 7'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [11:0] req_pc,
  input  logic [3:0]  req_flags,
  output logic        req_ready,
  output logic        done,
  output logic [11:0] ret_pc,
  output logic [3:0]  ret_flags,
  input  logic        sp_wr_en,
  input  logic [3:0]  sp_wr_data,
  output logic [3:0]  sp_rd,
  output logic [6:0]  mem_addr,
  output logic        mem_we,
  output logic [3:0]  mem_wdata,
  output logic        mem_re,
  input  logic [3:0]  mem_rdata
);
  localparam logic [1:0] OP_RETI  = 2'd3;
  localparam logic [3:0] TOP_LOC  = 4'd14;
  localparam logic [3:0] BAD_LOC  = 4'd15;

  typedef enum logic [2:0] {S_IDLE, S_SAVE, S_BUMP, S_LOAD, S_LAST} state_t;
  state_t state;

  logic [1:0]  op_q, idx, prev_idx, last_idx;
  logic [3:0]  sp_q, flags_q, sp_dec, sp_inc;
  logic [11:0] pc_q;
  logic        rd_pend, save_end;

  assign last_idx  = op_q[0] ? 2'd3 : 2'd2;
  assign sp_dec    = (sp_q == 4'd0) ? TOP_LOC : sp_q - 4'd1;
  assign sp_inc    = (sp_q == TOP_LOC) ? 4'd0 : sp_q + 4'd1;
  assign save_end  = (state == S_SAVE) && (idx == last_idx);
  assign req_ready = (state == S_IDLE);
  assign sp_rd     = sp_q;
  assign mem_we    = (state == S_SAVE);
  assign mem_re    = (state == S_LOAD);
  assign mem_addr  = BASE_ADDR + {1'b0, sp_q, 2'b00} + {5'b0, idx};

  always_comb
    case (idx)
      2'd0:    mem_wdata = pc_q[3:0];
      2'd1:    mem_wdata = pc_q[7:4];
      2'd2:    mem_wdata = pc_q[11:8];
      default: mem_wdata = flags_q;
    endcase

  always_ff @(posedge clk)
    if (save_end)
      sp_q <= sp_dec;
    else if (state == S_BUMP)
      sp_q <= sp_inc;
    else if (sp_wr_en && sp_wr_data != BAD_LOC)
      sp_q <= sp_wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= 2'd0;
      idx       <= 2'd0;
      prev_idx  <= 2'd0;
      rd_pend   <= 1'b0;
      done      <= 1'b0;
      pc_q      <= 12'd0;
      flags_q   <= 4'd0;
      ret_pc    <= 12'd0;
      ret_flags <= 4'd0;
    end else begin
      done     <= save_end || (state == S_LAST);
      rd_pend  <= (state == S_LOAD);
      prev_idx <= idx;
      if (rd_pend)
        case (prev_idx)
          2'd0:    ret_pc[3:0]  <= mem_rdata;
          2'd1:    ret_pc[7:4]  <= mem_rdata;
          2'd2:    ret_pc[11:8] <= mem_rdata;
          default: if (op_q == OP_RETI) ret_flags <= mem_rdata;
        endcase
      case (state)
        S_IDLE:
          if (req_valid) begin
            op_q    <= req_op;
            pc_q    <= req_pc;
            flags_q <= req_flags;
            idx     <= 2'd0;
            state   <= req_op[1] ? S_BUMP : S_SAVE;
          end
        S_SAVE:
          if (save_end) state <= S_IDLE;
          else          idx   <= idx + 2'd1;
        S_BUMP: begin
          idx   <= 2'd0;
          state <= S_LOAD;
        end
        S_LOAD:
          if (idx == last_idx) state <= S_LAST;
          else                 idx   <= idx + 2'd1;
        S_LAST:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/nibstack_ctrl_chk.sv
module nibstack_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       sp_wr_en,
  input logic [3:0] sp_rd,
  input logic [6:0] mem_addr,
  input logic       mem_we,
  input logic       mem_re,
  input logic [1:0] op_q
);
  logic [3:0] sp_prev, step_dn, step_up;
  logic       we_prev, primed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      primed  <= 1'b0;
      we_prev <= 1'b0;
      sp_prev <= 4'd0;
    end else begin
      primed  <= 1'b1;
      we_prev <= sp_wr_en;
      sp_prev <= sp_rd;
    end

  assign step_dn = (sp_prev == 4'd0)  ? 4'd14 : sp_prev - 4'd1;
  assign step_up = (sp_prev == 4'd14) ? 4'd0  : sp_prev + 4'd1;

  AST_NO_FIFTEEN: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> sp_rd != 4'hF); // R2
  AST_WRITE_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= 7'h40 && mem_addr <= 7'h7B)); // R3
  AST_CALL_KEEPS_SLOT3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[1:0] == 2'd3) |-> op_q == 2'd1); // R4
  AST_SP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !we_prev && sp_rd != sp_prev) |-> (sp_rd == step_dn || sp_rd == step_up)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_we && !mem_re)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
endmodule

bind nibstack_ctrl nibstack_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .sp_wr_en(sp_wr_en), .sp_rd(sp_rd), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_re(mem_re), .op_q(op_q)
);

// File: tb/nibstack_ctrl_test.sv
module nibstack_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [11:0] req_pc = 12'd0;
  logic [3:0] req_flags = 4'd0;
  logic sp_wr_en = 1'b0;
  logic [3:0] sp_wr_data = 4'd0;
  logic req_ready, done, mem_we, mem_re;
  logic [11:0] ret_pc;
  logic [3:0] ret_flags, sp_rd, mem_wdata;
  logic [3:0] mem_rdata = 4'd0;
  logic [6:0] mem_addr;
  logic [3:0] ram [128];
  int tests = 0, fails = 0, clashes = 0, strays = 0;

  always #5 clk = ~clk;

  nibstack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_pc(req_pc), .req_flags(req_flags), .req_ready(req_ready), .done(done),
    .ret_pc(ret_pc), .ret_flags(ret_flags), .sp_wr_en(sp_wr_en),
    .sp_wr_data(sp_wr_data), .sp_rd(sp_rd), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  always @(negedge clk)
    if (rst_n) begin
      if (mem_we && mem_re) clashes++;
      if (mem_we && (mem_addr < 7'h40 || mem_addr > 7'h7B)) strays++;
    end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_sp(input logic [3:0] v);
    @(negedge clk);
    sp_wr_en = 1'b1;
    sp_wr_data = v;
    @(negedge clk);
    sp_wr_en = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [11:0] pc, input logic [3:0] fl);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_pc = pc;
    req_flags = fl;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy", int'(req_ready), 0);
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R9 done", int'(done), 1);
  endtask

  task automatic done_drops();
    @(negedge clk);
    check("R9 pulse", int'(done), 0);
  endtask

  task automatic t_reset();
    check("R9 reset ready", int'(req_ready), 1);
    check("R9 reset done", int'(done), 0);
    check("R10 reset quiet", int'(mem_we | mem_re), 0);
  endtask

  task automatic t_pointer();
    set_sp(4'd12);
    check("R1 load", int'(sp_rd), 12);
    set_sp(4'd15);
    check("R2 write 15", int'(sp_rd), 12);
  endtask

  task automatic t_call();
    run_op(2'd0, 12'h3C5, 4'hE);
    check("R4 sp after call", int'(sp_rd), 11);
    done_drops();
    check("R3 pc lo", int'(ram[7'h70]), 5);
    check("R3 pc mid", int'(ram[7'h71]), 12);
    check("R3 pc hi", int'(ram[7'h72]), 3);
    check("R4 slot3 kept", int'(ram[7'h73]), 10);
  endtask

  task automatic t_irq();
    run_op(2'd1, 12'h9E1, 4'h6);
    check("R5 sp after irq", int'(sp_rd), 10);
    check("R5 pc lo", int'(ram[7'h6C]), 1);
    check("R5 pc hi", int'(ram[7'h6E]), 9);
    check("R5 flags", int'(ram[7'h6F]), 6);
  endtask

  task automatic t_reti_then_ret();
    run_op(2'd3, 12'h000, 4'h0);
    check("R7 sp", int'(sp_rd), 11);
    check("R7 pc", int'(ret_pc), 12'h9E1);
    check("R7 flags", int'(ret_flags), 6);
    run_op(2'd2, 12'h000, 4'h0);
    check("R6 sp", int'(sp_rd), 12);
    check("R6 pc", int'(ret_pc), 12'h3C5);
    check("R6 flags kept", int'(ret_flags), 6);
  endtask

  task automatic t_wrap();
    set_sp(4'd0);
    run_op(2'd0, 12'h2B7, 4'h0);
    check("R8 dec wraps", int'(sp_rd), 14);
    check("R8 overwrite", int'(ram[7'h40]), 7);
    run_op(2'd2, 12'h000, 4'h0);
    check("R8 inc wraps", int'(sp_rd), 0);
    check("R8 pc", int'(ret_pc), 12'h2B7);
    set_sp(4'd14);
    run_op(2'd1, 12'h5D0, 4'h9);
    check("R3 top flags", int'(ram[7'h7B]), 9);
    check("R5 sp", int'(sp_rd), 13);
    set_sp(4'd15);
    check("R2 ignored", int'(sp_rd), 13);
    run_op(2'd3, 12'h000, 4'h0);
    check("R7 top pc", int'(ret_pc), 12'h5D0);
    check("R7 top flags", int'(ret_flags), 9);
  endtask

  initial begin
    foreach (ram[i]) ram[i] = 4'd0;
    ram[7'h73] = 4'hA;
    ram[7'h40] = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_call();
    t_irq();
    t_reti_then_ret();
    t_wrap();
    check("R10 no clash", clashes, 0);
    check("R3 no stray writes", strays, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule